// File: doc/BRIEF.md
# Late-Write Pipelined Synchronous SRAM

A single-port synchronous memory with a shared data bus, split at the block edge into an input bus, an output bus and a drive enable for an external pad. Address, select, write and per-lane write enables are registered on the rising clock edge.

A read returns its word on the bus from the edge one full cycle after the address was sampled. A write takes its data from the bus on the edge one cycle after its command, which is late-write timing. That data is parked in a one-deep posted write buffer. The buffer is written into the array on a later deselect cycle, or when a write to a different address arrives. A read that targets the buffered address is served lane by lane from the buffer, so reads and writes stay coherent.

An output enable gates the drivers without waiting for a clock. A sleep input freezes the block and releases the bus. Depth, lane width and lane count are parameters; the default is a 64-word, 36-bit memory for simulation.

Top module: `lw_sram`

## Requirements
- R1: At each rising edge the command is decoded from active-low inputs. `sel_ni`=1 is a deselect. `sel_ni`=0 with `we_ni`=1 is a read. `sel_ni`=0 with `we_ni`=0 is a write of exactly the lanes whose `bwe_ni` bit is 0. A write with every `bwe_ni` bit at 1 is an abort.
- R2: After a read sampled at edge n, `dq_o` carries the stored word and `dq_oe_o` is 1 from edge n+1 until edge n+2.
- R3: For a write sampled at edge n, the data is taken from `dq_i` at edge n+1.
- R4: Lane i is bits [9i+8:9i] of the word and is enabled by `bwe_ni[i]`. A partial write leaves the other lanes at their previous values.
- R5: A read returns the most recent write's data for each lane, including back-to-back write-then-read and repeated writes to an address that is still buffered.
- R6: An abort changes no stored lane.
- R7: `dq_oe_o` is 0 during the cycle that follows a write, abort or deselect command.
- R8: While `oe_ni` is 1, `dq_oe_o` is 0 at once, including during a read data cycle.
- R9: While `sleep_i` is 1, commands sampled at that edge are ignored. A write data phase falling on a sleep edge is dropped. `dq_oe_o` is 0. Stored contents, including buffered data, are preserved.
- R10: After reset, `dq_oe_o` is 0 and no write is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sel_ni | input | 1 | Select, active low |
| we_ni | input | 1 | Write command, active low |
| bwe_ni | input | LANES | Per-lane write enable, active low |
| addr_i | input | AW | Word address |
| oe_ni | input | 1 | Asynchronous output enable, active low |
| sleep_i | input | 1 | Sleep, active high |
| dq_i | input | LANES*LANE_W | Bus value seen at the pad |
| dq_o | output | LANES*LANE_W | Read data towards the pad |
| dq_oe_o | output | 1 | Pad drive enable |

## Verification
The bench sets a command at a falling edge; the rising edge that follows samples it. It places that write's data on `dq_i` at the next falling edge, so the data meets the R3 capture edge. Read data and the drive enable are due after the second rising edge. The bench samples them at the second falling edge after the command, before it changes any input. The expected drive state at that moment uses the `oe_ni` and `sleep_i` values still applied, because both act without a clock. A reference memory applies each write at its data phase and drops the data phases that land on sleep edges. Read expectations are taken from this memory when the read is issued, which makes the posted buffer invisible, as coherence requires.

// File: rtl/lw_sram_pkg.sv
package lw_sram_pkg;
  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_DESEL,
    CMD_READ,
    CMD_WRITE,
    CMD_ABORT
  } cmd_e;
endpackage

// File: rtl/lw_sram_ctrl.sv
module lw_sram_ctrl
  import lw_sram_pkg::*;
#(
  parameter int AW    = 6,
  parameter int LANES = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] bwe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             sleep_i,
  output cmd_e             cmd_q_o,
  output logic [AW-1:0]    addr_q_o,
  output logic [LANES-1:0] be_q_o
);
  cmd_e cmd_d;

  always_comb begin
    if (sel_ni)        cmd_d = CMD_DESEL;
    else if (we_ni)    cmd_d = CMD_READ;
    else if (&bwe_ni)  cmd_d = CMD_ABORT;
    else               cmd_d = CMD_WRITE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_q_o  <= CMD_NOP;
      addr_q_o <= '0;
      be_q_o   <= '0;
    end else begin
      cmd_q_o  <= sleep_i ? CMD_NOP : cmd_d;
      addr_q_o <= addr_i;
      be_q_o   <= ~bwe_ni;
    end
  end

  // A registered write always carries at least one lane
  assert_write_has_lane_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q_o == CMD_WRITE) |-> (be_q_o != '0));
endmodule

// File: rtl/lw_sram_wbuf.sv
module lw_sram_wbuf
  import lw_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  cmd_e             cmd_q_i,
  input  logic [AW-1:0]    addr_q_i,
  input  logic [LANES-1:0] be_q_i,
  input  logic [DW-1:0]    wdata_i,
  output logic             wb_v_o,
  output logic [AW-1:0]    wb_addr_o,
  output logic [DW-1:0]    wb_data_o,
  output logic [LANES-1:0] wb_be_o,
  output logic             commit_o
);
  logic wr_phase, hit;

  assign wr_phase = (cmd_q_i == CMD_WRITE) && !sleep_i;
  assign hit      = wb_v_o && (wb_addr_o == addr_q_i);
  // retire on an idle port, or when a write to another address needs the slot
  assign commit_o = !sleep_i && wb_v_o &&
                    ((cmd_q_i == CMD_DESEL) || (wr_phase && !hit));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wb_v_o    <= 1'b0;
      wb_addr_o <= '0;
      wb_be_o   <= '0;
    end else if (wr_phase) begin
      wb_v_o    <= 1'b1;
      wb_addr_o <= addr_q_i;
      wb_be_o   <= hit ? (wb_be_o | be_q_i) : be_q_i;
    end else if (commit_o) begin
      wb_v_o <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        wb_data_o[g*LANE_W +: LANE_W] <= '0;
      end else if (wr_phase && (be_q_i[g] || !hit)) begin
        wb_data_o[g*LANE_W +: LANE_W] <= wdata_i[g*LANE_W +: LANE_W];
      end
    end
  end

  assert_buf_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_q_i inside {CMD_READ, CMD_ABORT, CMD_NOP}) || sleep_i)
      |=> ($stable(wb_v_o) && $stable(wb_addr_o) && $stable(wb_be_o) && $stable(wb_data_o)));

  assert_buf_load_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_phase |=> (wb_v_o && (wb_addr_o == $past(addr_q_i))));

  assert_commit_lanes_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    commit_o |-> (wb_be_o != '0));
endmodule

// File: rtl/lw_sram_array.sv
module lw_sram_array #(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W,
  localparam int DEPTH = 1 << AW
) (
  input  logic             clk_i,
  input  logic             we_i,
  input  logic [AW-1:0]    waddr_i,
  input  logic [LANES-1:0] be_i,
  input  logic [DW-1:0]    wdata_i,
  input  logic [AW-1:0]    raddr_i,
  output logic [DW-1:0]    rdata_o
);
  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [LANE_W-1:0] mem [DEPTH];
    always_ff @(posedge clk_i) begin
      if (we_i && be_i[g]) mem[waddr_i] <= wdata_i[g*LANE_W +: LANE_W];
    end
    assign rdata_o[g*LANE_W +: LANE_W] = mem[raddr_i];
  end

  always_comb begin
    if (we_i) assert_commit_mask_R4: assert (be_i != '0);
  end
endmodule

// File: rtl/lw_sram_rdpath.sv
module lw_sram_rdpath
  import lw_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sleep_i,
  input  logic             oe_ni,
  input  cmd_e             cmd_q_i,
  input  logic [AW-1:0]    addr_q_i,
  input  logic [DW-1:0]    arr_data_i,
  input  logic             wb_v_i,
  input  logic [AW-1:0]    wb_addr_i,
  input  logic [DW-1:0]    wb_data_i,
  input  logic [LANES-1:0] wb_be_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  logic [DW-1:0] merged;
  logic [DW-1:0] dout_q;
  logic          drive_q;
  logic          wb_hit;

  assign wb_hit = wb_v_i && (wb_addr_i == addr_q_i);

  // coherence: buffered lanes win over the array
  for (genvar g = 0; g < LANES; g++) begin : g_byp
    assign merged[g*LANE_W +: LANE_W] = (wb_hit && wb_be_i[g]) ?
        wb_data_i[g*LANE_W +: LANE_W] : arr_data_i[g*LANE_W +: LANE_W];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      drive_q <= 1'b0;
      dout_q  <= '0;
    end else if (sleep_i) begin
      drive_q <= 1'b0;
    end else begin
      drive_q <= (cmd_q_i == CMD_READ);
      if (cmd_q_i == CMD_READ) dout_q <= merged;
    end
  end

  assign dq_o    = dout_q;
  assign dq_oe_o = drive_q && !oe_ni && !sleep_i;

  assert_release_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_q_i inside {CMD_WRITE, CMD_DESEL, CMD_ABORT}) |=> !drive_q);

  assert_read_drive_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((cmd_q_i == CMD_READ) && !sleep_i) |=> drive_q);

  assert_sleep_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sleep_i |=> !drive_q);
endmodule

// File: rtl/lw_sram.sv
module lw_sram
  import lw_sram_pkg::*;
#(
  parameter int AW     = 6,
  parameter int LANES  = 4,
  parameter int LANE_W = 9,
  localparam int DW    = LANES * LANE_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_ni,
  input  logic             we_ni,
  input  logic [LANES-1:0] bwe_ni,
  input  logic [AW-1:0]    addr_i,
  input  logic             oe_ni,
  input  logic             sleep_i,
  input  logic [DW-1:0]    dq_i,
  output logic [DW-1:0]    dq_o,
  output logic             dq_oe_o
);
  cmd_e             cmd_q;
  logic [AW-1:0]    addr_q;
  logic [LANES-1:0] be_q;
  logic             wb_v, commit;
  logic [AW-1:0]    wb_addr;
  logic [DW-1:0]    wb_data, arr_data;
  logic [LANES-1:0] wb_be;

  lw_sram_ctrl #(.AW(AW), .LANES(LANES)) u_ctrl (
    .clk_i, .rst_ni, .sel_ni, .we_ni, .bwe_ni, .addr_i, .sleep_i,
    .cmd_q_o(cmd_q), .addr_q_o(addr_q), .be_q_o(be_q)
  );

  lw_sram_wbuf #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_wbuf (
    .clk_i, .rst_ni, .sleep_i,
    .cmd_q_i(cmd_q), .addr_q_i(addr_q), .be_q_i(be_q), .wdata_i(dq_i),
    .wb_v_o(wb_v), .wb_addr_o(wb_addr), .wb_data_o(wb_data), .wb_be_o(wb_be),
    .commit_o(commit)
  );

  lw_sram_array #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_array (
    .clk_i, .we_i(commit), .waddr_i(wb_addr), .be_i(wb_be), .wdata_i(wb_data),
    .raddr_i(addr_q), .rdata_o(arr_data)
  );

  lw_sram_rdpath #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_rdpath (
    .clk_i, .rst_ni, .sleep_i, .oe_ni,
    .cmd_q_i(cmd_q), .addr_q_i(addr_q), .arr_data_i(arr_data),
    .wb_v_i(wb_v), .wb_addr_i(wb_addr), .wb_data_i(wb_data), .wb_be_i(wb_be),
    .dq_o, .dq_oe_o
  );
endmodule

// File: tb/sim_lw_sram.sv
`timescale 1ns/1ps
module sim_lw_sram;
  localparam int AW = 6, LANES = 4, LANE_W = 9, DW = 36, DEPTH = 64;

  logic clk = 1'b0, rst_n = 1'b0;
  logic sel_n = 1'b1, we_n = 1'b1, oe_n = 1'b0, slp = 1'b0;
  logic [LANES-1:0] bwe_n = '1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] dq_in = '0, dq_out;
  logic dq_oe;

  int checks = 0, failures = 0;
  bit done = 0;
  string tag = "R10";

  // bench reference state
  logic [DW-1:0] ref_mem [DEPTH];
  logic e1 = 0, e2 = 0, p1_wr = 0, slp_prev = 0, oe_prev = 0;
  logic [DW-1:0] x1 = '0, x2 = '0, p1_data = '0;
  logic [AW-1:0] p1_addr = '0;
  logic [LANES-1:0] p1_be = '0;

  always #4 clk = ~clk;

  lw_sram #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .sel_ni(sel_n), .we_ni(we_n), .bwe_ni(bwe_n),
    .addr_i(addr), .oe_ni(oe_n), .sleep_i(slp), .dq_i(dq_in),
    .dq_o(dq_out), .dq_oe_o(dq_oe)
  );

  function automatic logic [DW-1:0] rnd_word();
    return {$urandom, $urandom};
  endfunction

  task automatic chk(input bit ok, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one command per cycle; wdat is this command's late-write data
  task automatic step(input logic s_n, input logic w_n, input logic [LANES-1:0] b_n,
                      input logic [AW-1:0] a, input logic o_n, input logic sl,
                      input logic [DW-1:0] wdat);
    logic exp_drv;
    @(negedge clk);
    exp_drv = e2 && !slp_prev && !oe_prev;
    chk(dq_oe == exp_drv, "drive", {35'd0, dq_oe}, {35'd0, exp_drv});
    if (exp_drv) chk(dq_out == x2, "read data", dq_out, x2);
    if (p1_wr && !sl)
      for (int i = 0; i < LANES; i++)
        if (p1_be[i]) ref_mem[p1_addr][i*LANE_W +: LANE_W] = p1_data[i*LANE_W +: LANE_W];
    dq_in = p1_wr ? p1_data : rnd_word();
    sel_n = s_n; we_n = w_n; bwe_n = b_n; addr = a; oe_n = o_n; slp = sl;
    e2 = e1; x2 = x1;
    e1 = !sl && !s_n && w_n;
    x1 = ref_mem[a];
    p1_wr = !sl && !s_n && !w_n && (b_n != '1);
    p1_addr = a; p1_be = ~b_n; p1_data = wdat;
    slp_prev = sl; oe_prev = o_n;
  endtask

  task automatic rd(input logic [AW-1:0] a);
    step(1'b0, 1'b1, '1, a, 1'b0, 1'b0, '0);
  endtask
  task automatic wr(input logic [AW-1:0] a, input logic [LANES-1:0] b_n, input logic [DW-1:0] d);
    step(1'b0, 1'b0, b_n, a, 1'b0, 1'b0, d);
  endtask
  task automatic idle();
    step(1'b1, 1'b1, '1, '0, 1'b0, 1'b0, '0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R10: idle bus after reset
    tag = "R10";
    @(negedge clk);
    chk(dq_oe == 1'b0, "drive after reset", {35'd0, dq_oe}, '0);
    // fill the array, full-lane writes
    tag = "R3";
    for (int i = 0; i < DEPTH; i++) wr(AW'(i), '0, rnd_word());
    idle();
    // R1, R2: plain reads, back to back
    tag = "R2";
    for (int i = 0; i < 6; i++) rd(AW'(i * 7));
    idle(); idle();
    // R4: partial lane writes, then read
    tag = "R4";
    wr(6'd3, 4'b1110, 36'h1_2345_6789);
    wr(6'd3, 4'b0111, 36'hA_BCDE_F012);
    idle(); rd(6'd3); idle(); idle();
    // R5: write immediately followed by read of the same address (buffer bypass)
    tag = "R5";
    wr(6'd9, 4'b0000, 36'h5_5555_5555);
    rd(6'd9);
    wr(6'd9, 4'b1101, 36'h0_00FF_FFFF);
    rd(6'd9);
    wr(6'd10, 4'b1011, 36'h9_8765_4321);
    rd(6'd9); rd(6'd10); idle(); idle();
    // R6: abort between buffered write and read
    tag = "R6";
    wr(6'd12, 4'b0000, 36'h3_3333_3333);
    step(1'b0, 1'b0, 4'b1111, 6'd12, 1'b0, 1'b0, 36'hF_FFFF_FFFF);
    rd(6'd12);
    step(1'b0, 1'b0, 4'b1111, 6'd13, 1'b0, 1'b0, 36'hE_EEEE_EEEE);
    rd(6'd13); idle(); idle();
    // R7: bus released after write, deselect and abort
    tag = "R7";
    rd(6'd1); wr(6'd2, 4'b0000, 36'h7_0707_0707); rd(6'd1); idle();
    rd(6'd1); step(1'b0, 1'b0, 4'b1111, 6'd2, 1'b0, 1'b0, '0); idle(); idle();
    // R8: output enable high during a read data cycle
    tag = "R8";
    rd(6'd4);
    step(1'b1, 1'b1, '1, '0, 1'b1, 1'b0, '0);
    rd(6'd5);
    idle(); idle();
    // R9: sleep drops a write data phase and keeps buffered data
    tag = "R9";
    wr(6'd20, 4'b0000, 36'h2_2222_2222);
    step(1'b0, 1'b1, '1, 6'd20, 1'b0, 1'b1, '0);
    rd(6'd20);
    wr(6'd21, 4'b0000, 36'h4_4444_4444);
    rd(6'd21);
    step(1'b1, 1'b1, '1, '0, 1'b0, 1'b1, '0);
    step(1'b0, 1'b0, 4'b0000, 6'd21, 1'b0, 1'b1, 36'h0);
    rd(6'd21); idle(); idle();
    // R1: command decode under constrained random traffic
    tag = "R1";
    for (int n = 0; n < 600; n++) begin
      int unsigned r = $urandom % 10;
      logic [AW-1:0] a = AW'($urandom % 8);
      logic o_n = ($urandom % 8) == 0;
      if (r < 4)       step(1'b0, 1'b1, '1, a, o_n, 1'b0, '0);
      else if (r < 7)  step(1'b0, 1'b0, LANES'($urandom), a, o_n, 1'b0, rnd_word());
      else if (r == 7) step(1'b0, 1'b0, '1, a, o_n, 1'b0, rnd_word());
      else if (r == 8) step(1'b1, 1'b1, '1, a, o_n, 1'b0, '0);
      else             step(1'b0, LANES'($urandom) == 0, LANES'($urandom), a, o_n, 1'b1, rnd_word());
    end
    tag = "R5";
    idle(); idle();
    for (int i = 0; i < 8; i++) rd(AW'(i));
    idle(); idle();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule